// File: doc/BRIEF.md
# Oscillator and PLL Control Unit

This block holds the software-visible controls for a main crystal oscillator and two frequency-synthesis PLLs. Software programs it through a plain register write port and a combinational read port. The block turns the register contents into three outputs. The first is a run indication for each source. The second is a ready indication for each source, raised after a programmable settle interval. The third is the output rate of each PLL, computed from a reference rate given at an input.

The crystal and the first PLL are kept running by hardware unless software takes control through an override bit. Only while that override bit is set does the matching enable bit decide whether the source runs. Writing the crystal register with the override clear and the enable set returns the crystal to its forced-running state, and a reset sequence depends on that state. The second PLL has no override: its enable bit gates it directly.

The first PLL's output rate is the reference multiplied by its multiplier field plus two, then shifted right by its divider field. The second PLL's output rate is the reference multiplied by its own multiplier field plus two, with no divider.

Top module: `osc_pll_ctrl`

## Requirements
- R1: After reset the crystal register (0x0C) reads 0x00000002, the PLL register (0x10) and the frequency register (0x14) read 0, the crystal and PLL1 run and PLL2 is stopped.
- R2: Only bits 0, 1, 19 and 20 of 0x0C, bits 0, 1, 28 and 29 of 0x10, and bits 2:0, 13:8 and 29:24 of 0x14 store written data. All other bits read zero. Reads of any other address return zero, and writes to any other address change nothing.
- R3: While bit 0 (crystal override) of 0x0C is 0, the crystal runs whatever bit 1 holds. While bit 0 is 1, the crystal runs exactly when bit 1 (crystal enable) is 1.
- R4: While bit 0 (PLL1 override) of 0x10 is 0, PLL1 runs whatever bit 1 holds. While bit 0 is 1, PLL1 runs exactly when bit 1 (PLL1 enable) is 1.
- R5: PLL2 runs exactly when bit 28 of 0x10 is 1, independent of the override bit.
- R6: A source's ready output rises SETTLE_CYCLES clock edges after the edge at which the source starts running, and falls in the same cycle the source stops. Bit 2 of 0x0C reads the crystal ready and bit 2 of 0x10 reads the PLL1 ready.
- R7: While PLL1 runs, its rate output equals (refRate × (M1 + 2)) >> D1, where M1 is bits 13:8 and D1 is bits 2:0 of 0x14.
- R8: While PLL2 runs, its rate output equals refRate × (M2 + 2), where M2 is bits 29:24 of 0x14.
- R9: A PLL rate output reads zero while that PLL is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| refRate | input | RATE_W (24) | Reference input rate |
| xtalOn | output | 1 | Crystal is running |
| pll1On | output | 1 | PLL1 is running |
| pll2On | output | 1 | PLL2 is running |
| xtalReady | output | 1 | Crystal settle interval has expired |
| pll1Ready | output | 1 | PLL1 settle interval has expired |
| pll2Ready | output | 1 | PLL2 settle interval has expired |
| pll1Rate | output | RATE_W+7 (31) | PLL1 output rate |
| pll2Rate | output | RATE_W+7 (31) | PLL2 output rate |

## Verification
The run gating is driven through all four override/enable combinations for both the crystal and PLL1. These cases tell the forced-running state apart from software control, and they show that PLL2 ignores the override. Ready timing is sampled one edge before and at the settle boundary, and again on the cycle of a disable, which separates an off-by-one settle count from a correct one. The rate formula is tried with a zero field, a mid-range multiplier with a nonzero shift, the largest shift, and the largest multiplier against a full-scale reference. These cases expose a missing +2 offset, a wrong field position, a divide in place of a shift, and truncation of the product.

// File: rtl/osc_pll_pkg.sv
package osc_pll_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] XTAL_ADDR = 8'h0C;
  localparam logic [ADDR_W-1:0] PLL_ADDR  = 8'h10;
  localparam logic [ADDR_W-1:0] FREQ_ADDR = 8'h14;

  // storage masks: bits that hold written data
  localparam logic [DATA_W-1:0] XTAL_WMASK = 32'h0018_0003;
  localparam logic [DATA_W-1:0] PLL_WMASK  = 32'h3000_0003;
  localparam logic [DATA_W-1:0] FREQ_WMASK = 32'h3F00_3F07;
  localparam logic [DATA_W-1:0] XTAL_RESET = 32'h0000_0002;

  localparam int MUL_W   = 6;
  localparam int SHIFT_W = 3;
  localparam int NUM_SRC = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic               xtalRun;
    logic               pll1Run;
    logic               pll2Run;
    logic [MUL_W-1:0]   mul1;
    logic [SHIFT_W-1:0] shift1;
    logic [MUL_W-1:0]   mul2;
  } pllCtl_t;
endpackage

// File: rtl/osc_pll_regs.sv
module osc_pll_regs
  import osc_pll_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              xtalReady,
  input  logic              pll1Ready,
  output logic [DATA_W-1:0] rdData,
  output pllCtl_t           ctl
);
  logic [DATA_W-1:0] xtalReg, pllReg, freqReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xtalReg <= XTAL_RESET;
      pllReg  <= '0;
      freqReg <= '0;
    end else if (wrEn) begin
      case (addr)
        XTAL_ADDR: xtalReg <= wrData & XTAL_WMASK;
        PLL_ADDR:  pllReg  <= wrData & PLL_WMASK;
        FREQ_ADDR: freqReg <= wrData & FREQ_WMASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      XTAL_ADDR: rdData = xtalReg | {{(DATA_W-3){1'b0}}, xtalReady, 2'b00};
      PLL_ADDR:  rdData = pllReg  | {{(DATA_W-3){1'b0}}, pll1Ready, 2'b00};
      FREQ_ADDR: rdData = freqReg;
      default:   rdData = '0;
    endcase
  end

  // override clear keeps the source running; set hands control to enable
  assign ctl.xtalRun = !xtalReg[0] || xtalReg[1];
  assign ctl.pll1Run = !pllReg[0]  || pllReg[1];
  assign ctl.pll2Run = pllReg[28];
  assign ctl.mul1    = freqReg[13:8];
  assign ctl.shift1  = freqReg[2:0];
  assign ctl.mul2    = freqReg[29:24];

  p_unmapped_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != XTAL_ADDR && addr != PLL_ADDR && addr != FREQ_ADDR) |=> $stable(ctl));

  p_xtal_forced_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == XTAL_ADDR && !wrData[0]) |=> ctl.xtalRun);

  p_pll1_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == PLL_ADDR && wrData[0]) |=> (ctl.pll1Run == $past(wrData[1])));

  p_pll2_direct_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == PLL_ADDR) |=> (ctl.pll2Run == $past(wrData[28])));
endmodule

// File: rtl/osc_settle.sv
module osc_settle #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic ready
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || !run) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ready = run && (cnt == LIMIT);

  p_ready_needs_prior_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(run));

  p_ready_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> (ready || !run));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIMIT);
endmodule

// File: rtl/osc_pll_rate.sv
module osc_pll_rate
  import osc_pll_pkg::*;
#(
  parameter int RATE_W = 24,
  localparam int OUT_W = RATE_W + MUL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] refRate,
  input  pllCtl_t           ctl,
  output logic [OUT_W-1:0]  pll1Rate,
  output logic [OUT_W-1:0]  pll2Rate
);
  logic [MUL_W:0]   factor1, factor2;
  logic [OUT_W-1:0] prod1, prod2, refWide;

  assign factor1 = {1'b0, ctl.mul1} + (MUL_W+1)'(2);
  assign factor2 = {1'b0, ctl.mul2} + (MUL_W+1)'(2);
  assign refWide = OUT_W'(refRate);
  assign prod1   = refWide * OUT_W'(factor1);
  assign prod2   = refWide * OUT_W'(factor2);

  assign pll1Rate = ctl.pll1Run ? (prod1 >> ctl.shift1) : '0;
  assign pll2Rate = ctl.pll2Run ? prod2 : '0;

  p_pll2_floor_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pll2Run |-> (pll2Rate >= (refWide << 1)));

  p_pll1_ceiling_r7: assert property (@(posedge clk) disable iff (!rstN)
    pll1Rate <= refWide * OUT_W'(65));
endmodule

// File: rtl/osc_pll_ctrl.sv
module osc_pll_ctrl
  import osc_pll_pkg::*;
#(
  parameter int RATE_W        = 24,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [7:0]                addr,
  input  logic [31:0]               wrData,
  output logic [31:0]               rdData,
  input  logic [RATE_W-1:0]         refRate,
  output logic                      xtalOn,
  output logic                      pll1On,
  output logic                      pll2On,
  output logic                      xtalReady,
  output logic                      pll1Ready,
  output logic                      pll2Ready,
  output logic [RATE_W+MUL_W:0]     pll1Rate,
  output logic [RATE_W+MUL_W:0]     pll2Rate
);
  pllCtl_t            ctl;
  logic [NUM_SRC-1:0] runVec, readyVec;

  osc_pll_regs uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .xtalReady(xtalReady), .pll1Ready(pll1Ready), .rdData(rdData), .ctl(ctl)
  );

  assign runVec = {ctl.pll2Run, ctl.pll1Run, ctl.xtalRun};

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSettle
    osc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) uSettle (
      .clk(clk), .rstN(rstN), .run(runVec[i]), .ready(readyVec[i])
    );
  end

  osc_pll_rate #(.RATE_W(RATE_W)) uRate (
    .clk(clk), .rstN(rstN), .refRate(refRate), .ctl(ctl),
    .pll1Rate(pll1Rate), .pll2Rate(pll2Rate)
  );

  assign {pll2On, pll1On, xtalOn}          = runVec;
  assign {pll2Ready, pll1Ready, xtalReady} = readyVec;
endmodule

// File: tb/sim_osc_pll_ctrl.sv
module sim_osc_pll_ctrl;
  localparam int S = 5;
  localparam int RW = 24;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [7:0] addr = 0;
  logic [31:0] wrData = 0, rdData;
  logic [RW-1:0] refRate = 0;
  logic xtalOn, pll1On, pll2On, xtalReady, pll1Ready, pll2Ready;
  logic [RW+6:0] pll1Rate, pll2Rate;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  osc_pll_ctrl #(.RATE_W(RW), .SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .refRate(refRate), .xtalOn(xtalOn), .pll1On(pll1On),
    .pll2On(pll2On), .xtalReady(xtalReady), .pll1Ready(pll1Ready),
    .pll2Ready(pll2Ready), .pll1Rate(pll1Rate), .pll2Rate(pll2Rate)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; #1;
    chk(tag, rdData, exp);
  endtask

  function automatic logic [63:0] rate1(logic [63:0] r, int m, int d);
    return (r * (m + 2)) >> d;
  endfunction

  task automatic t_reset;
    rstN = 0; repeat (3) @(negedge clk); rstN = 1;
    rd(8'h0C, 32'h2, "R1 xtal reg");
    rd(8'h10, 32'h0, "R1 pll reg");
    rd(8'h14, 32'h0, "R1 freq reg");
    chk("R1 run vector", {xtalOn, pll1On, pll2On}, 3'b110);
    repeat (S-1) @(negedge clk);
    chk("R6 xtal ready early", xtalReady, 0);
    @(negedge clk);
    chk("R6 xtal ready at limit", xtalReady, 1);
    chk("R6 pll1 ready at limit", pll1Ready, 1);
    rd(8'h0C, 32'h6, "R6 xtal status bit");
    rd(8'h10, 32'h4, "R6 pll1 status bit");
  endtask

  task automatic t_mask;
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, 32'h0018_0007, "R2 xtal mask");
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 32'h0, "R2 unmapped read");
    rd(8'h0C, 32'h0018_0007, "R2 unmapped write ignored");
    chk("R2 unmapped no run change", {xtalOn, pll1On, pll2On}, 3'b110);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, 32'h3000_0007, "R2 pll mask");
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, 32'h3F00_3F07, "R2 freq mask");
    wr(8'h0C, 32'h2); wr(8'h10, 32'h0); wr(8'h14, 32'h0);
  endtask

  task automatic t_xtal;
    wr(8'h0C, 32'h1);
    chk("R3 override, enable 0", xtalOn, 0);
    chk("R6 xtal ready drops", xtalReady, 0);
    rd(8'h0C, 32'h1, "R3 readback");
    wr(8'h0C, 32'h0);
    chk("R3 no override forces run", xtalOn, 1);
    rd(8'h0C, 32'h0, "R6 status not yet set");
    repeat (S-1) @(negedge clk);
    chk("R6 xtal ready early", xtalReady, 0);
    @(negedge clk);
    chk("R6 xtal ready at limit", xtalReady, 1);
    wr(8'h0C, 32'h3);
    chk("R3 override, enable 1", xtalOn, 1);
    rd(8'h0C, 32'h7, "R6 ready kept");
    wr(8'h0C, 32'h2);
    chk("R3 forced restore", xtalOn, 1);
  endtask

  task automatic t_pll1;
    wr(8'h10, 32'h1);
    chk("R4 override, enable 0", pll1On, 0);
    chk("R6 pll1 ready drops", pll1Ready, 0);
    wr(8'h10, 32'h3);
    chk("R4 override, enable 1", pll1On, 1);
    rd(8'h10, 32'h3, "R6 pll1 status low");
    repeat (S-1) @(negedge clk);
    chk("R6 pll1 ready early", pll1Ready, 0);
    @(negedge clk);
    rd(8'h10, 32'h7, "R6 pll1 status set");
    wr(8'h10, 32'h0);
    chk("R4 no override forces run", pll1On, 1);
    rd(8'h10, 32'h4, "R4 readback");
  endtask

  task automatic t_pll2;
    chk("R5 pll2 stopped", pll2On, 0);
    wr(8'h10, 32'h1000_0001);
    chk("R5 pll2 runs on bit 28", pll2On, 1);
    chk("R4 pll1 stopped alongside", pll1On, 0);
    chk("R6 pll2 ready low", pll2Ready, 0);
    repeat (S-1) @(negedge clk);
    chk("R6 pll2 ready early", pll2Ready, 0);
    @(negedge clk);
    chk("R6 pll2 ready at limit", pll2Ready, 1);
    wr(8'h10, 32'h0);
    chk("R5 pll2 stop", pll2On, 0);
    chk("R6 pll2 ready drops", pll2Ready, 0);
  endtask

  task automatic t_rate1;
    refRate = 1000; wr(8'h14, 32'h0A02);
    chk("R7 m10 d2", pll1Rate, rate1(1000, 10, 2));
    refRate = 1001; wr(8'h14, 32'h0503);
    chk("R7 m5 d3", pll1Rate, rate1(1001, 5, 3));
    refRate = 1000; wr(8'h14, 32'h0007);
    chk("R7 m0 d7", pll1Rate, rate1(1000, 0, 7));
    refRate = 24'hFFFFFF; wr(8'h14, 32'h3F00);
    chk("R7 max multiplier", pll1Rate, rate1(64'hFFFFFF, 63, 0));
  endtask

  task automatic t_rate2;
    refRate = 1000;
    wr(8'h10, 32'h1000_0000); wr(8'h14, 32'h1400_0000);
    chk("R8 m20", pll2Rate, 64'd22000);
    chk("R7 m0 d0", pll1Rate, 64'd2000);
    refRate = 24'hFFFFFF; wr(8'h14, 32'h3F00_0000);
    chk("R8 max multiplier", pll2Rate, 64'hFFFFFF * 65);
    wr(8'h10, 32'h1);
    chk("R9 pll1 rate zero", pll1Rate, 0);
    chk("R9 pll2 rate zero", pll2Rate, 0);
  endtask

  initial begin
    t_reset;
    t_mask;
    t_xtal;
    t_pll1;
    t_pll2;
    t_rate1;
    t_rate2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule